// File: doc/BRIEF.md
# Compare-Match ADC Trigger Generator

This block derives two separate A/D conversion start pulses from a free-running 16-bit timer count. Three compare values are checked for equality against the count. Each of the two trigger outputs has its own enable mask, which picks the compare matches that may fire it, and its own decimation select, which lets only every first, second, fourth or eighth qualifying event through as a pulse.

A match counts only in the cycle where equality begins and only while the timer is counting up. A third output carries a pin-level copy of the pulses so they can be watched externally. The timer, the phase outputs, register reloading and interrupts are outside this block. The enable input gates the whole block.

Top module: `adc_trig_gen`

## Requirements
- R1: A compare value produces an event only in the first cycle in which `cnt` equals it. If `cnt` holds at a compare value over several cycles, the result is a single event.
- R2: A match gives an event only when `cnt_up` is 1 in that cycle. Matches while `cnt_up` is 0 produce no pulse.
- R3: Mask bit 0, 1 and 2 enable the up-count matches of `cmp0`, `cmp1` and `cmp2`. Mask bits 3 to 7 are reserved for down-count, valley and sub-counter events. They are inert and never produce a pulse.
- R4: Several enabled matches in the same cycle count as one event for that output.
- R5: Rate select 00, 01, 10 and 11 emit a pulse on every 1st, 2nd, 4th and 8th qualifying event. Counting restarts from reset, and the first event after a restart always pulses.
- R6: A cycle in which an output's rate select differs from its value in the previous cycle restarts that output's count, so an event in that cycle or later pulses first.
- R7: While `en` is 0, no pulses are produced and both skip counts return to their start. The first event after `en` returns to 1 pulses.
- R8: A pulse appears in the cycle after the match cycle and lasts one clock per event.
- R9: `trig_pin` is high exactly when `trig_a` or `trig_b` is high.
- R10: During reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable |
| cnt | input | 16 | Timer count value |
| cnt_up | input | 1 | 1 while the timer counts up |
| cmp0 | input | 16 | Compare value 0 |
| cmp1 | input | 16 | Compare value 1 |
| cmp2 | input | 16 | Compare value 2 |
| mask_a | input | 8 | Event enable mask of trigger A |
| mask_b | input | 8 | Event enable mask of trigger B |
| rate_a | input | 2 | Decimation select of trigger A |
| rate_b | input | 2 | Decimation select of trigger B |
| trig_a | output | 1 | Trigger A pulse |
| trig_b | output | 1 | Trigger B pulse |
| trig_pin | output | 1 | Pin-level copy of the trigger pulses |

## Verification
On every cycle the assertions check four things. A disabled block stays silent. A down-counting cycle never leads to a pulse. Each skip count stays inside the range of its selected rate. Every pulse has a matching enabled compare value in the previous cycle behind it. The pulse-count ratios of the decimation, the single event of a held count, the merging of simultaneous matches and the restarts after a rate change or a disable can only be shown by the bench scenarios. These scenarios sweep every rate on both outputs over repeated count ramps.

// File: rtl/adc_trig_gen.sv
module adc_trig_gen #(
  parameter int CW  = 16,
  parameter int MW  = 8,
  parameter int SKW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_up,
  input  logic [CW-1:0] cmp0,
  input  logic [CW-1:0] cmp1,
  input  logic [CW-1:0] cmp2,
  input  logic [MW-1:0] mask_a,
  input  logic [MW-1:0] mask_b,
  input  logic [1:0]    rate_a,
  input  logic [1:0]    rate_b,
  output logic          trig_a,
  output logic          trig_b,
  output logic          trig_pin
);
  localparam int NCMP = 3;
  localparam int NOUT = 2;

  logic [CW-1:0]   cmp_arr  [NCMP];
  logic [MW-1:0]   mask_arr [NOUT];
  logic [1:0]      rate_arr [NOUT];
  logic [NOUT-1:0] trig_v;
  logic [NCMP-1:0] hit, hit_q, rise;

  assign cmp_arr[0]  = cmp0;
  assign cmp_arr[1]  = cmp1;
  assign cmp_arr[2]  = cmp2;
  assign mask_arr[0] = mask_a;
  assign mask_arr[1] = mask_b;
  assign rate_arr[0] = rate_a;
  assign rate_arr[1] = rate_b;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = (cnt == cmp_arr[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit;
  end

  assign rise = hit & ~hit_q;

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [1:0]     rate_q;
    logic [SKW-1:0] skip_q, lim, eff;
    logic           ev, trig_r;

    assign lim = (SKW'(1) << rate_arr[k]) - SKW'(1);
    assign ev  = en && cnt_up && |(rise & mask_arr[k][NCMP-1:0]);
    assign eff = (rate_arr[k] != rate_q) ? '0 : skip_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rate_q <= '0;
        skip_q <= '0;
        trig_r <= 1'b0;
      end else begin
        rate_q <= rate_arr[k];
        trig_r <= ev && (eff == '0);
        if (!en)     skip_q <= '0;
        else if (ev) skip_q <= (eff + SKW'(1)) & lim;
        else         skip_q <= eff;
      end
    end

    assign trig_v[k] = trig_r;

    p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !trig_r);
    p_down_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_up |=> !trig_r);
    p_skip_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_arr[k] == rate_q) |-> ((skip_q & ~lim) == '0));
    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_r |-> $past(|(hit & mask_arr[k][NCMP-1:0])));
  end

  assign trig_a   = trig_v[0];
  assign trig_b   = trig_v[1];
  assign trig_pin = |trig_v;
endmodule

// File: tb/tb_adc_trig_gen.sv
module tb_adc_trig_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [15:0] cnt = '0;
  logic        cnt_up = 1'b1;
  logic [15:0] cmp0 = 16'd3, cmp1 = 16'd10, cmp2 = 16'd10;
  logic [7:0]  mask_a = '0, mask_b = '0;
  logic [1:0]  rate_a = '0, rate_b = '0;
  logic        trig_a, trig_b, trig_pin;

  int n_chk = 0, n_bad = 0, pa = 0, pb = 0;
  logic [2:0] m_hitq = '0;
  logic [1:0] m_rq [2] = '{2'd0, 2'd0};
  int         m_skip [2] = '{0, 0};
  logic       e_t [2] = '{1'b0, 1'b0};

  always #10 clk = ~clk;

  adc_trig_gen dut (.clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .cnt_up(cnt_up),
    .cmp0(cmp0), .cmp1(cmp1), .cmp2(cmp2), .mask_a(mask_a), .mask_b(mask_b),
    .rate_a(rate_a), .rate_b(rate_b), .trig_a(trig_a), .trig_b(trig_b), .trig_pin(trig_pin));

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cnt(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual count %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [2:0] h, r;
    logic [1:0] rt [2];
    logic [7:0] mk [2];
    h = {cnt == cmp2, cnt == cmp1, cnt == cmp0};
    r = h & ~m_hitq;
    m_hitq = h;
    rt[0] = rate_a; rt[1] = rate_b;
    mk[0] = mask_a; mk[1] = mask_b;
    for (int k = 0; k < 2; k++) begin
      int eff, div;
      logic ev;
      div = 1 << rt[k];
      eff = (rt[k] != m_rq[k]) ? 0 : m_skip[k];
      ev  = en && cnt_up && ((r & mk[k][2:0]) != 0);
      e_t[k] = ev && (eff == 0);
      if (!en)     m_skip[k] = 0;
      else if (ev) m_skip[k] = (eff + 1) % div;
      else         m_skip[k] = eff;
      m_rq[k] = rt[k];
    end
    @(posedge clk);
    #1;
    check({tag, " R8 trig_a"}, trig_a, e_t[0]);
    check({tag, " R8 trig_b"}, trig_b, e_t[1]);
    check("R9 trig_pin", trig_pin, e_t[0] | e_t[1]);
    if (trig_a) pa++;
    if (trig_b) pb++;
  endtask

  task automatic ramp(int laps, logic up, string tag);
    for (int l = 0; l < laps; l++)
      for (int v = 0; v < 40; v++) begin
        cnt = up ? 16'(v) : 16'(39 - v);
        cnt_up = up;
        step(tag);
      end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 trig_a", trig_a, 1'b0);
    check("R10 trig_b", trig_b, 1'b0);
    check("R10 trig_pin", trig_pin, 1'b0);
    rst_n = 1'b1;

    // R4 R5: cmp1 == cmp2 merges; 18 events per config
    mask_a = 8'h07; mask_b = 8'h05;
    for (int ra = 0; ra < 4; ra++) begin
      rate_a = 2'(ra); rate_b = 2'(3 - ra);
      pa = 0; pb = 0;
      ramp(9, 1'b1, "R5");
      check_cnt("R4 R5 count a", pa, (18 + (1 << ra) - 1) >> ra);
      check_cnt("R5 count b", pb, (18 + (1 << (3 - ra)) - 1) >> (3 - ra));
    end

    // R3: only inert bits set
    rate_a = 0; rate_b = 0; mask_a = 8'hF8; mask_b = 8'hF8;
    pa = 0; pb = 0;
    ramp(2, 1'b1, "R3");
    check_cnt("R3 inert a", pa, 0);
    check_cnt("R3 inert b", pb, 0);

    // R2: down count, every mask bit set
    mask_a = 8'hFF; mask_b = 8'hFF;
    pa = 0; pb = 0;
    ramp(2, 1'b0, "R2");
    check_cnt("R2 down a", pa, 0);
    check_cnt("R2 down b", pb, 0);

    // R1: count holds at a compare value
    mask_a = 8'h01; mask_b = 8'h00; cmp0 = 16'd20; cnt_up = 1'b1;
    pa = 0;
    cnt = 16'd19; step("R1");
    cnt = 16'd20;
    for (int i = 0; i < 6; i++) step("R1");
    cnt = 16'd21; step("R1");
    check_cnt("R1 hold a", pa, 1);

    // R6: rate change restarts
    rate_a = 2'd3;
    ramp(3, 1'b1, "R6");
    rate_a = 2'd2; pa = 0;
    ramp(1, 1'b1, "R6");
    check_cnt("R6 restart a", pa, 1);

    // R7: disable restarts and silences
    rate_a = 2'd1;
    ramp(1, 1'b1, "R7");
    en = 1'b0; pa = 0;
    ramp(1, 1'b1, "R7");
    check_cnt("R7 off a", pa, 0);
    en = 1'b1;
    ramp(1, 1'b1, "R7");
    check_cnt("R7 resume a", pa, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule